// File: doc/BRIEF.md
# Dual-Queue Conversion Command Arbiter

This block runs conversion commands from two independent command queues on one shared converter. Both queues read from a common 64-entry command table. Each queue keeps its own pointer into that table and has its own trigger sources. At any moment a queue is in one of four states: waiting for a trigger, pending, executing, or paused.

Every cycle the arbiter looks at the pending queues and picks which one runs next. Queue 1 has strict priority. A pending queue 1 command takes the converter from a queue 2 conversion that is in progress. The aborted conversion yields no result. Queue 2 keeps the aborted index and executes that command again once queue 1 stops at a pause or at the end of its list.

The table is outside the block. It is read combinationally through an address/data port pair. The converter is modelled internally as a fixed-latency counter. Each completed conversion produces a one-cycle strobe that carries the command index and the owning queue.

Top module: `dual_queue_conv_sched`

## Requirements
- R1: After a synchronous active-low reset, both queues report state 0 (idle), the converter is not busy, and no result, abort or overrun strobe is high.
- R2: A queue in state 0 (idle) or state 3 (paused) that sees a trigger goes to state 1 (pending) on the next edge. From idle, its pointer is first loaded with its start index: 0 for queue 1, `q2_begin` for queue 2. Queue 1 triggers are the external and software-scan pulses. Queue 2 triggers are the same two plus the timer tick.
- R3: A command word carries the channel in bits [5:0] and the pause flag in bit 6. When the granted queue's word has channel 63, no conversion starts. The queue returns to state 0 and its pointer is reset to its start index.
- R4: A granted command starts on the grant edge. `conv_busy` then stays high for exactly 16 cycles, and state 2 (active) is reported for the owner. In the cycle after, `res_valid` pulses once with the command index in `res_idx` and the owner in `res_queue` (0 = queue 1, 1 = queue 2).
- R5: After it completes a command whose pause flag is set, a queue enters state 3. It resumes from the following index on its next trigger.
- R6: When both queues are pending and the converter is free, queue 1 is served first.
- R7: If queue 1 is pending while a queue 2 conversion is running and not in its final cycle, that conversion is aborted on that edge. `abort_evt` pulses for one cycle, no result is produced for the aborted command, and queue 1's command starts at once.
- R8: An aborted queue 2 returns to state 1 with its pointer on the aborted index. It runs that command again after queue 1 pauses or ends.
- R9: A queue 2 request never aborts or delays a queue 1 conversion in progress.
- R10: A trigger that arrives while its queue is in state 1 or 2 raises that queue's overrun pulse in the next cycle and has no other effect.
- R11: A queue 2 conversion in its final cycle is not aborted. It delivers its result, and a queue 1 request raised in that cycle starts on the following edge.
- R12: When a queue's continuous-mode input is high, reaching channel 63 sends the queue straight back to state 1 at its start index. The end of the list then acts as a new trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q1_ext_trig | input | 1 | Queue 1 external trigger pulse |
| q1_sw_scan | input | 1 | Queue 1 software single-scan pulse |
| q1_cont | input | 1 | Queue 1 continuous mode |
| q2_ext_trig | input | 1 | Queue 2 external trigger pulse |
| q2_sw_scan | input | 1 | Queue 2 software single-scan pulse |
| q2_timer_tick | input | 1 | Queue 2 periodic timer expiry pulse |
| q2_cont | input | 1 | Queue 2 continuous mode |
| q2_begin | input | 6 | Queue 2 start index |
| cmd_addr | output | 6 | Command table read address |
| cmd_word | input | 7 | Command word at `cmd_addr` (pause, channel) |
| conv_busy | output | 1 | Converter occupied |
| conv_owner | output | 1 | Owner of running conversion (0 = queue 1) |
| res_valid | output | 1 | One-cycle result-write strobe |
| res_queue | output | 1 | Queue owning the result |
| res_idx | output | 6 | Command index of the result |
| abort_evt | output | 1 | One-cycle pulse after an abort |
| q1_ovr | output | 1 | Queue 1 trigger-overrun pulse |
| q2_ovr | output | 1 | Queue 2 trigger-overrun pulse |
| q1_state | output | 2 | Queue 1 state (0 idle, 1 pending, 2 active, 3 paused) |
| q2_state | output | 2 | Queue 2 state (same encoding) |

## Verification
Completion of a queue 2 conversion and its preemption by queue 1 can fall in the same cycle. The bench provokes this by raising the queue 1 trigger exactly sixteen edges after a queue 2 trigger, so that queue 1 becomes pending in queue 2's final busy cycle. It judges the outcome in two ways. The abort count must stay unchanged, and the result log must show the queue 2 command first, followed by queue 1's commands. An every-cycle behavioural model independently checks the exact cycle of each state change, strobe and pointer.

// File: rtl/convq_pkg.sv
// Shared types for the dual-queue conversion arbiter.
// Assumes: state encoding is visible at the top ports, so its values are fixed.
package convq_pkg;

    typedef enum logic [1:0] {
        QS_IDLE   = 2'd0,
        QS_PEND   = 2'd1,
        QS_ACTIVE = 2'd2,
        QS_PAUSED = 2'd3
    } qstate_e;

endpackage

// File: rtl/convq_queue.sv
// Per-queue sequencer: holds the queue state and its table pointer,
// captures triggers and flags triggers that arrive while busy.
// Assumes: grant, preempt and done never target this queue in a state
// other than the one they are meant for (arbiter guarantees it).
module convq_queue
    import convq_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [IDX_W-1:0] begin_ptr,
    input  logic             cont_mode,
    input  logic             grant,
    input  logic             eoq,
    input  logic             done,
    input  logic             done_pause,
    input  logic             preempt,
    output qstate_e          state,
    output logic [IDX_W-1:0] ptr,
    output logic             ovr
);

    // State, pointer and overrun flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= QS_IDLE;
            ptr   <= '0;
            ovr   <= 1'b0;
        end else begin
            ovr <= trig && (state == QS_PEND || state == QS_ACTIVE);
            case (state)
                QS_IDLE: begin
                    if (trig) begin
                        state <= QS_PEND;
                        ptr   <= begin_ptr;
                    end
                end
                QS_PAUSED: begin
                    if (trig) state <= QS_PEND;
                end
                QS_PEND: begin
                    if (grant) begin
                        if (eoq) begin
                            state <= cont_mode ? QS_PEND : QS_IDLE;
                            ptr   <= begin_ptr;
                        end else begin
                            state <= QS_ACTIVE;
                        end
                    end
                end
                QS_ACTIVE: begin
                    if (preempt) begin
                        state <= QS_PEND;
                    end else if (done) begin
                        ptr   <= ptr + IDX_W'(1);
                        state <= done_pause ? QS_PAUSED : QS_PEND;
                    end
                end
                default: state <= QS_IDLE;
            endcase
        end
    end

    // R10
    ovr_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> ($past(state) == QS_PEND || $past(state) == QS_ACTIVE));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == QS_IDLE && !trig) |=> state == QS_IDLE);

    // R7
    preempt_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preempt |-> state == QS_ACTIVE);

endmodule

// File: rtl/convq_arbiter.sv
// Combinational grant logic for the shared converter.
// Queue 1 wins over queue 2; queue 1 may take the converter from a
// queue 2 conversion unless that conversion is in its final cycle.
// Assumes: owner is 0 for queue 1, 1 for queue 2.
module convq_arbiter (
    input  logic       pend1,
    input  logic       pend2,
    input  logic       busy,
    input  logic       owner,
    input  logic       finishing,
    output logic [1:0] gnt
);

    // Priority selection between the two pending queues.
    always_comb begin
        gnt    = 2'b00;
        gnt[0] = pend1 && (!busy || (owner && !finishing));
        gnt[1] = pend2 && !busy && !pend1;
    end

endmodule

// File: rtl/convq_conv_stub.sv
// Fixed-latency converter model: a start occupies it for CONV_CYCLES
// cycles, then a result strobe follows. A start while busy is an abort
// of the running conversion, which then yields no result.
// Assumes: start never coincides with finishing.
module convq_conv_stub #(
    parameter int IDX_W       = 6,
    parameter int CONV_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_owner,
    input  logic [IDX_W-1:0] start_idx,
    input  logic             start_pause,
    output logic             busy,
    output logic             owner,
    output logic [IDX_W-1:0] idx,
    output logic             cur_pause,
    output logic             finishing,
    output logic             res_valid,
    output logic             res_owner,
    output logic [IDX_W-1:0] res_idx,
    output logic             abort_pulse
);

    localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign finishing = busy && (cnt == LAST);

    // Occupancy counter, conversion record and result/abort strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            owner       <= 1'b0;
            idx         <= '0;
            cur_pause   <= 1'b0;
            cnt         <= '0;
            res_valid   <= 1'b0;
            res_owner   <= 1'b0;
            res_idx     <= '0;
            abort_pulse <= 1'b0;
        end else begin
            res_valid   <= finishing;
            res_owner   <= owner;
            res_idx     <= idx;
            abort_pulse <= start && busy;
            if (start) begin
                busy      <= 1'b1;
                owner     <= start_owner;
                idx       <= start_idx;
                cur_pause <= start_pause;
                cnt       <= '0;
            end else if (finishing) begin
                busy <= 1'b0;
            end else if (busy) begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // R11
    no_abort_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !finishing);

    // R4
    busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finishing && !start) |=> (busy && cnt == $past(cnt) + CNT_W'(1)));

    // R7
    abort_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> !res_valid);

endmodule

// File: rtl/dual_queue_conv_sched.sv
// Top of the dual-queue conversion arbiter: merges trigger sources,
// instantiates both queue sequencers, the arbiter and the converter
// model, and performs the command fetch for the granted queue.
// Assumes: the command table answers cmd_addr combinationally; channel
// all-ones marks end of queue; queue 1 starts at index 0.
module dual_queue_conv_sched
    import convq_pkg::*;
#(
    parameter int IDX_W       = 6,
    parameter int CHAN_W      = 6,
    parameter int CONV_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q1_ext_trig,
    input  logic              q1_sw_scan,
    input  logic              q1_cont,
    input  logic              q2_ext_trig,
    input  logic              q2_sw_scan,
    input  logic              q2_timer_tick,
    input  logic              q2_cont,
    input  logic [IDX_W-1:0]  q2_begin,
    output logic [IDX_W-1:0]  cmd_addr,
    input  logic [CHAN_W:0]   cmd_word,
    output logic              conv_busy,
    output logic              conv_owner,
    output logic              res_valid,
    output logic              res_queue,
    output logic [IDX_W-1:0]  res_idx,
    output logic              abort_evt,
    output logic              q1_ovr,
    output logic              q2_ovr,
    output logic [1:0]        q1_state,
    output logic [1:0]        q2_state
);

    localparam int NQ = 2;
    localparam logic [CHAN_W-1:0] EOQ_CHAN = '1;

    logic [NQ-1:0]    trig, cont, gnt, q_done, q_preempt, ovr, pend;
    logic [IDX_W-1:0] begin_ptr [NQ];
    logic [IDX_W-1:0] ptr [NQ];
    qstate_e          st [NQ];

    logic             busy, owner, finishing, cur_pause, start, eoq;
    logic [IDX_W-1:0] cur_idx;

    // Trigger source merging per queue.
    assign trig[0]      = q1_ext_trig | q1_sw_scan;
    assign trig[1]      = q2_ext_trig | q2_sw_scan | q2_timer_tick;
    assign cont[0]      = q1_cont;
    assign cont[1]      = q2_cont;
    assign begin_ptr[0] = '0;
    assign begin_ptr[1] = q2_begin;

    // Command fetch for the queue that would be granted.
    assign cmd_addr = pend[0] ? ptr[0] : ptr[1];
    assign eoq      = (cmd_word[CHAN_W-1:0] == EOQ_CHAN);
    assign start    = (|gnt) && !eoq;

    assign q_preempt[0] = 1'b0;
    assign q_preempt[1] = start && busy;

    for (genvar q = 0; q < NQ; q++) begin : g_queue
        assign pend[q]   = (st[q] == QS_PEND);
        assign q_done[q] = finishing && (owner == 1'(q));

        convq_queue #(.IDX_W(IDX_W)) u_queue (
            .clk        (clk),
            .rst_n      (rst_n),
            .trig       (trig[q]),
            .begin_ptr  (begin_ptr[q]),
            .cont_mode  (cont[q]),
            .grant      (gnt[q]),
            .eoq        (eoq),
            .done       (q_done[q]),
            .done_pause (cur_pause),
            .preempt    (q_preempt[q]),
            .state      (st[q]),
            .ptr        (ptr[q]),
            .ovr        (ovr[q])
        );
    end

    convq_arbiter u_arb (
        .pend1     (pend[0]),
        .pend2     (pend[1]),
        .busy      (busy),
        .owner     (owner),
        .finishing (finishing),
        .gnt       (gnt)
    );

    convq_conv_stub #(.IDX_W(IDX_W), .CONV_CYCLES(CONV_CYCLES)) u_conv (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_owner (gnt[1]),
        .start_idx   (cmd_addr),
        .start_pause (cmd_word[CHAN_W]),
        .busy        (busy),
        .owner       (owner),
        .idx         (cur_idx),
        .cur_pause   (cur_pause),
        .finishing   (finishing),
        .res_valid   (res_valid),
        .res_owner   (res_queue),
        .res_idx     (res_idx),
        .abort_pulse (abort_evt)
    );

    assign conv_busy  = busy;
    assign conv_owner = owner;
    assign q1_ovr     = ovr[0];
    assign q2_ovr     = ovr[1];
    assign q1_state   = st[0];
    assign q2_state   = st[1];

    // R9
    q2_no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |-> owner == 1'b1);

    // R6
    q1_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] && pend[1] && !busy) |=> st[1] == QS_PEND);

    // R8
    resume_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_preempt[1] |=> (st[1] == QS_PEND && ptr[1] == $past(cur_idx)));

endmodule

// File: tb/dual_queue_conv_sched_tb.sv
`timescale 1ns/1ps
module dual_queue_conv_sched_tb;

    localparam int LAT = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n;
    logic [4:0] trg;   // 0 q1 ext, 1 q1 sw, 2 q2 ext, 3 q2 sw, 4 q2 tick
    logic       q1_cont, q2_cont;
    logic [5:0] q2_begin;
    logic [5:0] cmd_addr, res_idx;
    logic [6:0] cmd_word;
    logic       conv_busy, conv_owner, res_valid, res_queue, abort_evt, q1_ovr, q2_ovr;
    logic [1:0] q1_state, q2_state;
    logic [6:0] tbl [64];

    assign cmd_word = tbl[cmd_addr];

    dual_queue_conv_sched u_dut (
        .clk(clk), .rst_n(rst_n),
        .q1_ext_trig(trg[0]), .q1_sw_scan(trg[1]), .q1_cont(q1_cont),
        .q2_ext_trig(trg[2]), .q2_sw_scan(trg[3]), .q2_timer_tick(trg[4]),
        .q2_cont(q2_cont), .q2_begin(q2_begin),
        .cmd_addr(cmd_addr), .cmd_word(cmd_word),
        .conv_busy(conv_busy), .conv_owner(conv_owner),
        .res_valid(res_valid), .res_queue(res_queue), .res_idx(res_idx),
        .abort_evt(abort_evt), .q1_ovr(q1_ovr), .q2_ovr(q2_ovr),
        .q1_state(q1_state), .q2_state(q2_state)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    int  mst [2], mptr [2];
    int  mbusy, mown, midx, mpause, mcnt, mres_v, mres_q, mres_i, mabort;
    int  movr [2];
    bit  started = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int q = 0; q < 2; q++) begin mst[q] = 0; mptr[q] = 0; movr[q] = 0; end
            mbusy = 0; mown = 0; midx = 0; mpause = 0; mcnt = 0;
            mres_v = 0; mres_q = 0; mres_i = 0; mabort = 0;
            started = 1;
        end else begin
            int t [2];
            int p1, p2, fin, g1, g2, addr, w, eoq, g, nst, nptr;
            t[0] = int'(trg[0] | trg[1]);
            t[1] = int'(trg[2] | trg[3] | trg[4]);
            p1   = (mst[0] == 1);
            p2   = (mst[1] == 1);
            fin  = (mbusy != 0 && mcnt == LAT - 1);
            g1   = p1 && (!mbusy || (mown == 1 && !fin));
            g2   = p2 && !mbusy && !p1;
            addr = p1 ? mptr[0] : mptr[1];
            w    = int'(tbl[addr]);
            eoq  = ((w % 64) == 63);
            mres_v = fin; mres_q = mown; mres_i = midx;
            mabort = (g1 || g2) && !eoq && mbusy;
            for (int q = 0; q < 2; q++) begin
                movr[q] = t[q] && (mst[q] == 1 || mst[q] == 2);
                g    = (q == 0) ? g1 : g2;
                nst  = mst[q];
                nptr = mptr[q];
                case (mst[q])
                    0: if (t[q] != 0) begin nst = 1; nptr = (q == 0) ? 0 : int'(q2_begin); end
                    3: if (t[q] != 0) nst = 1;
                    1: if (g != 0) begin
                        if (eoq != 0) begin
                            nst  = (((q == 0) ? q1_cont : q2_cont) != 0) ? 1 : 0;
                            nptr = (q == 0) ? 0 : int'(q2_begin);
                        end else nst = 2;
                    end
                    default: begin
                        if (q == 1 && mabort != 0) nst = 1;
                        else if (fin != 0 && mown == q) begin
                            nptr = (mptr[q] + 1) % 64;
                            nst  = (mpause != 0) ? 3 : 1;
                        end
                    end
                endcase
                mst[q] = nst; mptr[q] = nptr;
            end
            if ((g1 || g2) && !eoq) begin
                mbusy = 1; mown = g2 ? 1 : 0; midx = addr; mpause = (w / 64) % 2; mcnt = 0;
            end else if (fin) mbusy = 0;
            else if (mbusy != 0) mcnt++;
        end
    end

    // Result log and event counters, sampled at the falling edge.
    int lq [64], li [64];
    int nlog = 0, naborts = 0, novr1 = 0;

    always @(negedge clk) begin
        if (started && rst_n && !finished) begin
            chk("R2", "q1_state", int'(q1_state), mst[0]);
            chk("R2", "q2_state", int'(q2_state), mst[1]);
            chk("R3", "cmd_addr", int'(cmd_addr), (mst[0] == 1) ? mptr[0] : mptr[1]);
            chk("R4", "conv_busy", int'(conv_busy), mbusy);
            if (mbusy != 0) chk("R9", "conv_owner", int'(conv_owner), mown);
            chk("R4", "res_valid", int'(res_valid), mres_v);
            if (mres_v != 0) begin
                chk("R4", "res_queue", int'(res_queue), mres_q);
                chk("R4", "res_idx", int'(res_idx), mres_i);
            end
            chk("R7", "abort_evt", int'(abort_evt), mabort);
            chk("R10", "q1_ovr", int'(q1_ovr), movr[0]);
            chk("R10", "q2_ovr", int'(q2_ovr), movr[1]);
            if (res_valid && nlog < 64) begin
                lq[nlog] = int'(res_queue); li[nlog] = int'(res_idx); nlog++;
            end
            if (abort_evt) naborts++;
            if (q1_ovr) novr1++;
        end
    end

    task automatic pulse(int b);
        trg[b] = 1'b1;
        @(negedge clk);
        trg[b] = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic exp_res(string tag, int k, int q, int i);
        chk(tag, $sformatf("result %0d queue", k), lq[k], q);
        chk(tag, $sformatf("result %0d index", k), li[k], i);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) tbl[i] = 7'(i % 63);
        tbl[0]  = 7'd1;  tbl[1]  = 7'h40 | 7'd2; tbl[2] = 7'd3; tbl[3] = 7'd4; tbl[4] = 7'd63;
        tbl[10] = 7'd10; tbl[11] = 7'd11; tbl[12] = 7'd12; tbl[13] = 7'd63;
        rst_n = 1'b0; trg = '0; q1_cont = 1'b0; q2_cont = 1'b0; q2_begin = 6'd10;
        wait_cyc(3);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "q1_state", int'(q1_state), 0);
        chk("R1", "q2_state", int'(q2_state), 0);
        chk("R1", "conv_busy", int'(conv_busy), 0);
        chk("R1", "res_valid", int'(res_valid), 0);
        chk("R1", "abort_evt", int'(abort_evt), 0);

        // R5: queue 1 stops at its paused command
        nlog = 0; pulse(0); wait_cyc(50);
        chk("R5", "result count", nlog, 2);
        exp_res("R5", 0, 0, 0); exp_res("R5", 1, 0, 1);
        chk("R5", "q1 paused", int'(q1_state), 3);

        // R3: resume, then end of queue returns to idle
        nlog = 0; pulse(1); wait_cyc(50);
        chk("R3", "result count", nlog, 2);
        exp_res("R3", 0, 0, 2); exp_res("R3", 1, 0, 3);
        chk("R3", "q1 idle", int'(q1_state), 0);

        // R7/R8: queue 1 aborts a running queue 2 conversion, which is redone
        nlog = 0; pulse(4); wait_cyc(6); pulse(0); wait_cyc(120);
        chk("R7", "abort count", naborts, 1);
        chk("R8", "result count", nlog, 5);
        exp_res("R7", 0, 0, 0); exp_res("R7", 1, 0, 1);
        exp_res("R8", 2, 1, 10); exp_res("R8", 3, 1, 11); exp_res("R8", 4, 1, 12);

        // R10: second trigger while queue 1 is active is only flagged
        nlog = 0; pulse(1); wait_cyc(5); pulse(0); wait_cyc(50);
        chk("R10", "overrun pulses", novr1, 1);
        chk("R10", "result count", nlog, 2);
        exp_res("R10", 0, 0, 2); exp_res("R10", 1, 0, 3);
        chk("R10", "q1 idle", int'(q1_state), 0);

        // R9: queue 2 request waits behind running queue 1
        nlog = 0; pulse(0); wait_cyc(3); pulse(3); wait_cyc(120);
        chk("R9", "abort count", naborts, 1);
        chk("R9", "result count", nlog, 5);
        exp_res("R9", 0, 0, 0); exp_res("R9", 1, 0, 1); exp_res("R9", 2, 1, 10);

        // R11: queue 1 becomes pending in queue 2's final busy cycle
        nlog = 0; pulse(2); wait_cyc(15); pulse(1); wait_cyc(130);
        chk("R11", "abort count", naborts, 1);
        chk("R11", "result count", nlog, 5);
        exp_res("R11", 0, 1, 10); exp_res("R11", 1, 0, 2); exp_res("R11", 2, 0, 3);
        exp_res("R11", 3, 1, 11); exp_res("R11", 4, 1, 12);

        // R12: continuous mode restarts queue 2 from its start index
        nlog = 0; q2_cont = 1'b1; pulse(2); wait_cyc(80); q2_cont = 1'b0; wait_cyc(80);
        chk("R12", "result count", nlog, 6);
        exp_res("R12", 2, 1, 12); exp_res("R12", 3, 1, 10); exp_res("R12", 5, 1, 12);
        chk("R12", "q2 idle", int'(q2_state), 0);

        // R6: simultaneous triggers, queue 1 first; new begin pointer for queue 2
        nlog = 0; q2_begin = 6'd12; trg[0] = 1'b1; trg[3] = 1'b1;
        @(negedge clk); trg = '0; wait_cyc(80);
        chk("R6", "result count", nlog, 3);
        exp_res("R6", 0, 0, 0); exp_res("R6", 1, 0, 1); exp_res("R6", 2, 1, 12);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk("WDOG", "watchdog expired", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule